// File: doc/BRIEF.md
# Idle-Gap Checkpoint Write Trigger

This block sits beside one DRAM rank and decides when that rank may send a checkpoint page write to the non-volatile store. Each cycle it is told whether the rank serves a demand access (busy) or sits idle. It counts the idle cycles of the current gap and fires a one-cycle write strobe once the run reaches the threshold in force. A cold dirty page must also be ready. The write stays outstanding until the non-volatile path reports completion.

One gap can hold several writes. A small vector of thresholds supplies the arming level for each of them in turn. Entry 0 arms the first write of a gap. When a write completes and no demand access has broken the gap, the idle count starts again from zero against the next entry. A demand access always wins over checkpoint traffic. It clears the count and sends the block back to entry 0. A demand access that reaches the rank while a write is still in flight is stalled until that write ends. The block totals how many cycles such stalls cost, using a fixed write occupancy of `WPCM` cycles.

The controller has three states. COUNT counts idle cycles against the current entry. INFLIGHT waits for write completion. SPENT means the gap has used up every valid entry. The transitions are: COUNT to INFLIGHT when the write fires; COUNT to SPENT when the current entry lies past the valid count; INFLIGHT to COUNT on completion; SPENT to COUNT on a busy cycle. A busy cycle in COUNT keeps the state at COUNT and clears the count and index.

Top module: `idle_ckpt_trigger`

## Requirements
- R1: While reset is held and on the first cycle after it, `wr_issue_o` is 0 and all three statistics read 0.
- R2: In COUNT with entry k in force, the strobe fires in the gap cycle whose earlier idle-cycle count equals `thr_vec_i[k*TW +: TW]`. Gap cycles are numbered from 0, so a threshold of 0 fires on the first idle cycle.
- R3: No write fires while `cold_avail_i` is 0. The idle count keeps running, so the strobe fires in the first cycle `cold_avail_i` is 1 if the count already meets the threshold.
- R4: No write fires in a cycle with `busy_i` at 1. A busy cycle clears the idle count and returns the index to entry 0. This includes a busy cycle that falls while a write is in flight.
- R5: The strobe fires on a cycle after `wr_done_i` is seen in an unbroken gap. The cycle after completion is idle cycle 0 of a fresh count, and the next entry is in force.
- R6: At most one write is outstanding. No strobe fires between a strobe and the next `wr_done_i`.
- R7: Once the index reaches `thr_cnt_i` (or `NTHR`, whichever is smaller), no write fires until a busy cycle.
- R8: Take a write issued in cycle c. The first busy cycle c+e that falls before its completion adds `WPCM-e` to `stat_delay_o`, or 0 if e is at least `WPCM`. If that amount is nonzero, it also raises `stat_delayed_o` by 1. Later busy cycles during the same write add nothing.
- R9: `stat_writes_o` rises by 1 on the clock edge that ends each strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Demand access in this cycle |
| cold_avail_i | input | 1 | A cold dirty page is ready to be written |
| thr_vec_i | input | NTHR*TW | Threshold entries; entry k sits at bits k*TW +: TW |
| thr_cnt_i | input | $clog2(NTHR+1) | Number of valid entries |
| wr_done_i | input | 1 | Non-volatile write completed |
| wr_issue_o | output | 1 | One-cycle write strobe |
| stat_writes_o | output | SW | Writes issued |
| stat_delayed_o | output | SW | Writes that stalled a demand access |
| stat_delay_o | output | SW | Total stall cycles charged |

## Verification
The hardest case to reach is a demand access that lands on an in-flight write, followed by completion. The checks are that the stall is charged once and that the next write is armed by entry 0 rather than the next entry. The bench builds this directly. It opens a gap and lets the first write fire. It raises busy a chosen number of cycles later, and again on the following cycle, then completes the write. It then confirms that the next strobe appears after the first threshold and that the penalty equals `WPCM` minus that distance. A second write with busy arriving after the occupancy has run out checks that a zero charge leaves the stalled-write count unchanged.

// File: rtl/idle_ckpt_pkg.sv
package idle_ckpt_pkg;

    typedef enum logic [1:0] {
        ST_COUNT    = 2'd0,
        ST_INFLIGHT = 2'd1,
        ST_SPENT    = 2'd2
    } gap_state_e;

endpackage

// File: rtl/idle_run_counter.sv
module idle_run_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + CW'(1);
        end
    end

endmodule

// File: rtl/thr_select.sv
module thr_select #(
    parameter int NTHR = 4,
    parameter int TW   = 12,
    parameter int IW   = $clog2(NTHR + 1)
) (
    input  logic [NTHR*TW-1:0] thr_vec_i,
    input  logic [IW-1:0]      thr_cnt_i,
    input  logic [IW-1:0]      idx_i,
    output logic [TW-1:0]      thr_o,
    output logic               valid_o
);

    logic [TW-1:0] entry [NTHR];

    for (genvar g = 0; g < NTHR; g++) begin : g_unpack
        assign entry[g] = thr_vec_i[g*TW +: TW];
    end

    always_comb begin
        thr_o = '0;
        for (int k = 0; k < NTHR; k++) begin
            if (idx_i == IW'(k)) begin
                thr_o = entry[k];
            end
        end
    end

    assign valid_o = (idx_i < thr_cnt_i) && (idx_i < IW'(NTHR));

endmodule

// File: rtl/gap_stats.sv
module gap_stats #(
    parameter int WPCM = 1000,
    parameter int SW   = 32,
    parameter int EW   = $clog2(WPCM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          inflight_i,
    input  logic          busy_i,
    output logic [SW-1:0] writes_o,
    output logic [SW-1:0] delayed_o,
    output logic [SW-1:0] delay_o
);

    localparam logic [EW-1:0] OCC = EW'(WPCM);

    logic [EW-1:0] elapsed;
    logic          charged;
    logic [EW-1:0] pen;
    logic          charge_now;

    assign charge_now = inflight_i && busy_i && !charged;
    assign pen        = (elapsed < OCC) ? (OCC - elapsed) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
            charged <= 1'b0;
        end else if (start_i) begin
            elapsed <= EW'(1);
            charged <= 1'b0;
        end else if (inflight_i) begin
            if (elapsed < OCC) begin
                elapsed <= elapsed + EW'(1);
            end
            if (busy_i) begin
                charged <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            writes_o  <= '0;
            delayed_o <= '0;
            delay_o   <= '0;
        end else begin
            if (start_i) begin
                writes_o <= writes_o + SW'(1);
            end
            if (charge_now && pen != '0) begin
                delayed_o <= delayed_o + SW'(1);
                delay_o   <= delay_o + SW'(pen);
            end
        end
    end

endmodule

// File: rtl/idle_ckpt_trigger.sv
module idle_ckpt_trigger
    import idle_ckpt_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int TW   = 12,
    parameter int WPCM = 1000,
    parameter int SW   = 32,
    parameter int IW   = $clog2(NTHR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              cold_avail_i,
    input  logic [NTHR*TW-1:0] thr_vec_i,
    input  logic [IW-1:0]     thr_cnt_i,
    input  logic              wr_done_i,
    output logic              wr_issue_o,
    output logic [SW-1:0]     stat_writes_o,
    output logic [SW-1:0]     stat_delayed_o,
    output logic [SW-1:0]     stat_delay_o
);

    gap_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          broken_q, broken_d;
    logic [TW-1:0] idle_cnt;
    logic [TW-1:0] thr_cur;
    logic          thr_ok;
    logic          fire;
    logic          cnt_clr;
    logic          cnt_inc;

    idle_run_counter #(.CW(TW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (idle_cnt)
    );

    thr_select #(.NTHR(NTHR), .TW(TW), .IW(IW)) u_sel (
        .thr_vec_i (thr_vec_i),
        .thr_cnt_i (thr_cnt_i),
        .idx_i     (idx_q),
        .thr_o     (thr_cur),
        .valid_o   (thr_ok)
    );

    gap_stats #(.WPCM(WPCM), .SW(SW)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (fire),
        .inflight_i (state_q == ST_INFLIGHT),
        .busy_i     (busy_i),
        .writes_o   (stat_writes_o),
        .delayed_o  (stat_delayed_o),
        .delay_o    (stat_delay_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_COUNT;
            idx_q    <= '0;
            broken_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            broken_q <= broken_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        broken_d = broken_q;
        unique case (state_q)
            ST_COUNT: begin
                if (busy_i) begin
                    idx_d = '0;
                end else if (!thr_ok) begin
                    state_d = ST_SPENT;
                end else if (fire) begin
                    state_d  = ST_INFLIGHT;
                    broken_d = 1'b0;
                end
            end
            ST_INFLIGHT: begin
                if (busy_i) begin
                    broken_d = 1'b1;
                end
                if (wr_done_i) begin
                    state_d = ST_COUNT;
                    if (busy_i || broken_q) begin
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + IW'(1);
                    end
                end
            end
            ST_SPENT: begin
                if (busy_i) begin
                    state_d = ST_COUNT;
                    idx_d   = '0;
                end
            end
            default: begin
                state_d = ST_COUNT;
                idx_d   = '0;
            end
        endcase
    end

    // Outputs and counter controls
    always_comb begin
        fire    = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                fire    = !busy_i && cold_avail_i && thr_ok && (idle_cnt >= thr_cur);
                cnt_clr = busy_i || fire;
                cnt_inc = !busy_i && !fire;
            end
            ST_INFLIGHT: begin
                cnt_clr = 1'b1;
            end
            ST_SPENT: begin
                cnt_clr = 1'b1;
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
    end

    assign wr_issue_o = fire;

endmodule

// File: rtl/idle_ckpt_trigger_chk.sv
module idle_ckpt_trigger_chk #(
    parameter int WPCM = 1000,
    parameter int SW   = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_i,
    input logic          cold_avail_i,
    input logic          wr_done_i,
    input logic          wr_issue_o,
    input logic [SW-1:0] stat_writes_o,
    input logic [SW-1:0] stat_delayed_o,
    input logic [SW-1:0] stat_delay_o
);

    logic outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (wr_issue_o) begin
            outstanding <= 1'b1;
        end else if (wr_done_i) begin
            outstanding <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (stat_writes_o == '0 || $past(rst_n)); // R1
        end
    end

    AST_NO_FIRE_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue_o |-> cold_avail_i); // R3

    AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue_o |-> !busy_i); // R4

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue_o |-> !outstanding); // R6

    AST_WRITES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue_o |=> stat_writes_o == $past(stat_writes_o) + SW'(1)); // R9

    AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_issue_o |=> (stat_delay_o - $past(stat_delay_o)) < SW'(WPCM)); // R8

    AST_DELAYED_NEEDS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(outstanding && busy_i) |=> stat_delayed_o == $past(stat_delayed_o)); // R8

endmodule

bind idle_ckpt_trigger idle_ckpt_trigger_chk #(.WPCM(WPCM), .SW(SW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy_i         (busy_i),
    .cold_avail_i   (cold_avail_i),
    .wr_done_i      (wr_done_i),
    .wr_issue_o     (wr_issue_o),
    .stat_writes_o  (stat_writes_o),
    .stat_delayed_o (stat_delayed_o),
    .stat_delay_o   (stat_delay_o)
);

// File: tb/tb_idle_ckpt_trigger.sv
`timescale 1ns/1ps
module tb_idle_ckpt_trigger;

    localparam int NTHR = 4;
    localparam int TW   = 12;
    localparam int WPCM = 24;
    localparam int SW   = 32;
    localparam int IW   = $clog2(NTHR + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              busy_i = 1'b1;
    logic              cold_avail_i = 1'b0;
    logic [NTHR*TW-1:0] thr_vec_i = '0;
    logic [IW-1:0]     thr_cnt_i = '0;
    logic              wr_done_i = 1'b0;
    logic              wr_issue_o;
    logic [SW-1:0]     stat_writes_o, stat_delayed_o, stat_delay_o;

    int checks = 0;
    int fails  = 0;
    int exp_writes = 0, exp_delayed = 0, exp_delay = 0;
    bit summary_done = 1'b0;

    always #2.5 clk = ~clk;

    idle_ckpt_trigger #(.NTHR(NTHR), .TW(TW), .WPCM(WPCM), .SW(SW)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .busy_i         (busy_i),
        .cold_avail_i   (cold_avail_i),
        .thr_vec_i      (thr_vec_i),
        .thr_cnt_i      (thr_cnt_i),
        .wr_done_i      (wr_done_i),
        .wr_issue_o     (wr_issue_o),
        .stat_writes_o  (stat_writes_o),
        .stat_delayed_o (stat_delayed_o),
        .stat_delay_o   (stat_delay_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_thr(input int t0, input int t1, input int t2, input int t3, input int n);
        thr_vec_i = {TW'(t3), TW'(t2), TW'(t1), TW'(t0)};
        thr_cnt_i = IW'(n);
    endtask

    // Drive one cycle and check the strobe in that cycle
    task automatic cyc(input bit b, input bit c, input bit d, input bit exp_iss, input string req);
        @(negedge clk);
        busy_i = b; cold_avail_i = c; wr_done_i = d;
        #1;
        check(req, int'(wr_issue_o), int'(exp_iss));
        if (exp_iss) exp_writes++;
    endtask

    task automatic idle_run(input int n, input bit c, input string req);
        for (int k = 0; k < n; k++) cyc(1'b0, c, 1'b0, 1'b0, req);
    endtask

    task automatic check_stats(input string req);
        @(posedge clk); #1;
        check({req, " writes"},  int'(stat_writes_o),  exp_writes);
        check({req, " delayed"}, int'(stat_delayed_o), exp_delayed);
        check({req, " delay"},   int'(stat_delay_o),   exp_delay);
    endtask

    task automatic t_reset();
        check("R1 strobe", int'(wr_issue_o), 0);
        check_stats("R1");
    endtask

    task automatic t_multi_write();
        set_thr(2, 5, 1, 3, 4);
        cyc(1, 1, 0, 0, "R4 busy");
        idle_run(2, 1'b1, "R2 before thr0");
        cyc(0, 1, 0, 1, "R2 fire at thr0");
        idle_run(3, 1'b1, "R6 in flight");
        cyc(0, 1, 1, 0, "R6 done cycle");
        idle_run(5, 1'b1, "R5 before thr1");
        cyc(0, 1, 0, 1, "R5 fire at thr1");
        cyc(0, 1, 1, 0, "R6 done cycle");
        idle_run(1, 1'b1, "R5 before thr2");
        cyc(0, 1, 0, 1, "R5 fire at thr2");
        cyc(0, 1, 1, 0, "R6 done cycle");
        idle_run(3, 1'b1, "R5 before thr3");
        cyc(0, 1, 0, 1, "R5 fire at thr3");
        cyc(0, 1, 1, 0, "R6 done cycle");
        idle_run(6, 1'b1, "R7 vector used up");
        cyc(1, 1, 0, 0, "R4 busy");
        check_stats("R9");
    endtask

    task automatic t_cold_gate();
        set_thr(2, 5, 1, 3, 4);
        cyc(1, 1, 0, 0, "R4 busy");
        idle_run(4, 1'b0, "R3 no cold page");
        cyc(0, 1, 0, 1, "R3 fire when cold arrives");
        cyc(0, 0, 1, 0, "R6 done cycle");
        cyc(1, 0, 0, 0, "R4 busy");
        check_stats("R3");
    endtask

    task automatic t_busy_priority();
        set_thr(2, 5, 1, 3, 4);
        cyc(1, 1, 0, 0, "R4 busy");
        idle_run(2, 1'b1, "R4 before thr0");
        cyc(1, 1, 0, 0, "R4 busy blocks write");
        idle_run(2, 1'b1, "R4 count restarted");
        cyc(0, 1, 0, 1, "R4 fire after restart");
        cyc(0, 1, 1, 0, "R6 done cycle");
        cyc(1, 1, 0, 0, "R4 busy");
        check_stats("R4");
    endtask

    task automatic t_exhaust();
        set_thr(0, 0, 7, 7, 2);
        cyc(1, 1, 0, 0, "R4 busy");
        cyc(0, 1, 0, 1, "R2 zero threshold fires at once");
        cyc(0, 1, 1, 0, "R6 done cycle");
        cyc(0, 1, 0, 1, "R5 second zero threshold");
        cyc(0, 1, 1, 0, "R6 done cycle");
        idle_run(8, 1'b1, "R7 count limit reached");
        cyc(1, 1, 0, 0, "R7 busy rearms");
        cyc(0, 1, 0, 1, "R7 fire after rearm");
        cyc(0, 1, 1, 0, "R6 done cycle");
        cyc(1, 1, 0, 0, "R4 busy");
        check_stats("R7");
    endtask

    task automatic t_penalty();
        set_thr(2, 5, 1, 3, 4);
        cyc(1, 1, 0, 0, "R4 busy");
        idle_run(2, 1'b1, "R2 before thr0");
        cyc(0, 1, 0, 1, "R2 fire");
        idle_run(4, 1'b1, "R6 in flight");
        cyc(1, 1, 0, 0, "R8 clash at e=5");
        exp_delayed++; exp_delay += WPCM - 5;
        cyc(1, 1, 0, 0, "R8 second busy not charged");
        cyc(0, 1, 1, 0, "R6 done cycle");
        idle_run(2, 1'b1, "R4 broken gap back to entry 0");
        cyc(0, 1, 0, 1, "R4 fire at thr0 not thr1");
        idle_run(29, 1'b1, "R6 in flight long");
        cyc(1, 1, 0, 0, "R8 clash after occupancy");
        cyc(0, 1, 1, 0, "R6 done cycle");
        cyc(1, 1, 0, 0, "R4 busy");
        check_stats("R8");
    endtask

    initial begin
        #(200000 * 5);
        if (!summary_done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary_done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 strobe in reset", int'(wr_issue_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_multi_write();
        t_cold_gate();
        t_busy_priority();
        t_exhaust();
        t_penalty();
        summary_done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule